// File: doc/BRIEF.md
# Split-Capable Bus Slave Response Controller

This block is the response front end of a slow slave on a multi-master AHB system. It watches the address phase of each transfer and decides how the data phase ends. Idle cycles get an immediate OKAY. A write into a protected address window gets an ERROR. A transfer that the backing store can serve gets OKAY, with wait states inserted while the store is still busy. When the store stays busy too long, the block gives up the bus with a SPLIT response and notes which master it turned away.

The block keeps a record of every master it has split. When the backing store reports ready, it raises that master's bit on the 16-bit split-complete output for exactly one cycle, so the arbiter lets the master back in. The master's retried transfer then finishes with a zero-wait OKAY and the record is cleared. The storage array and the address decoder sit outside this block.

Top module: `ahb_split_slave`

## Requirements
- R1: Under reset and straight after it, `hreadyout` is 1, `hresp` is OKAY (00) and `hsplit` is all zero.
- R2: An address phase with `htrans` IDLE (00) or BUSY (01), or with `hsel` low, gets a zero-wait OKAY: `hreadyout` stays 1 and `hresp` stays 00 in the next cycle, whatever `mem_ready` is.
- R3: Address, control, `hsel` and `hmaster` are taken only at an edge where `hready` is 1. A NONSEQ (10) or SEQ (11) transfer shown while `hready` is 0 has no effect.
- R4: A write whose `haddr` lies in the inclusive window `RO_LO`..`RO_HI` ends with ERROR (`hresp` 01) over two cycles: `hreadyout` 0 in the first, 1 in the second, `hresp` 01 in both. A read of the same window is served normally.
- R5: An accepted transfer with `mem_ready` high at the accepting edge completes with zero wait states and OKAY.
- R6: An accepted transfer with `mem_ready` low holds `hreadyout` at 0 with OKAY; when `mem_ready` is seen high at an edge within the wait limit, `hreadyout` returns to 1 with OKAY in the next cycle.
- R7: If `mem_ready` stays low for `WAIT_LIMIT` wait cycles (limit 1 to 16), the block answers SPLIT (`hresp` 11) over two cycles, `hreadyout` 0 then 1, and records the `hmaster` value sampled with the transfer as pending.
- R8: While `mem_ready` is high and some pending master has not yet been signalled, `hsplit` carries that master's bit (bit index = master number) for one cycle; with several, the lowest master number goes first, one bit per cycle.
- R9: A transfer accepted from a master that is pending and already signalled completes with zero-wait OKAY regardless of `mem_ready`, clears its record, and produces no further `hsplit` pulse; its next transfer is handled as a fresh one.
- R10: While `mem_ready` is low, `hsplit` stays all zero even with masters pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select from the decoder |
| haddr | input | ADDR_W | Transfer address |
| htrans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hwrite | input | 1 | 1 for write, 0 for read |
| hready | input | 1 | Bus-wide ready; address phase taken only when 1 |
| hmaster | input | 4 | Number of the master owning the address phase |
| mem_ready | input | 1 | Backing store can serve the access |
| hreadyout | output | 1 | This slave's data phase is complete |
| hresp | output | 2 | Response: 00 OKAY, 01 ERROR, 11 SPLIT |
| hsplit | output | 16 | One-cycle split-complete bit per master |

## Verification
The bench drives the SPLIT path end to end: two masters are turned away in turn, then the store becomes ready and the bench expects two single-cycle pulses in ascending master order; a design that forgot to index by the recorded master, or held the pulse, shows the wrong bit or a second cycle. The retry of a signalled master is issued with the store still busy, so a design that ignored its record would insert wait states instead of the zero-wait OKAY, and a repeat transfer afterwards must wait again, which catches a record that is never cleared. The wait count is probed exactly at its limit, and an ERROR or SPLIT that drops `hresp` in its second cycle or skips the low-ready first cycle is caught cycle by cycle. A transfer shown under a low `hready` and idle or busy transfers shown with the store busy expose a slave that samples when it should not.

// File: rtl/ahb_split_slave.sv
module ahb_split_slave #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WAIT_LIMIT = 4,
  parameter logic [ADDR_W-1:0] RO_LO = 'h8000,
  parameter logic [ADDR_W-1:0] RO_HI = 'h8fff
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic              hready,
  input  logic [3:0]        hmaster,
  input  logic              mem_ready,
  output logic              hreadyout,
  output logic [1:0]        hresp,
  output logic [15:0]       hsplit
);
  localparam int unsigned CNT_W = $clog2(WAIT_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_LIMIT - 1);
  localparam logic [1:0] RSP_OKAY  = 2'b00;
  localparam logic [1:0] RSP_ERROR = 2'b01;
  localparam logic [1:0] RSP_SPLIT = 2'b11;

  typedef enum logic [1:0] {S_DONE, S_WAIT, S_RESP1, S_RESP2} st_t;

  st_t              st;
  logic [1:0]       rsp_q;
  logic [3:0]       mst_q;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      pend, sent;

  wire        open_ph  = (st == S_DONE) || (st == S_RESP2);
  wire        accept   = hsel & hready & htrans[1] & open_ph;
  wire        ro_hit   = hwrite && (haddr >= RO_LO) && (haddr <= RO_HI);
  wire        retry_ok = pend[hmaster] & sent[hmaster];
  wire [15:0] cand     = pend & ~sent;
  wire [15:0] pick     = cand & (~cand + 16'd1);

  assign hreadyout = open_ph;
  assign hresp     = (st == S_RESP1 || st == S_RESP2) ? rsp_q : RSP_OKAY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_DONE;
      rsp_q  <= RSP_OKAY;
      mst_q  <= '0;
      cnt    <= '0;
      pend   <= '0;
      sent   <= '0;
      hsplit <= '0;
    end else begin
      hsplit <= '0;
      if (mem_ready && cand != '0) begin
        hsplit <= pick;
        sent   <= sent | pick;
      end
      case (st)
        S_DONE, S_RESP2: begin
          st <= S_DONE;
          if (accept) begin
            mst_q <= hmaster;
            if (ro_hit) begin
              st    <= S_RESP1;
              rsp_q <= RSP_ERROR;
            end else if (retry_ok) begin
              pend[hmaster] <= 1'b0;
              sent[hmaster] <= 1'b0;
            end else if (!mem_ready) begin
              st  <= S_WAIT;
              cnt <= '0;
            end
          end
        end
        S_WAIT: begin
          if (mem_ready) begin
            st <= S_DONE;
          end else if (cnt == CNT_LAST) begin
            st          <= S_RESP1;
            rsp_q       <= RSP_SPLIT;
            pend[mst_q] <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_RESP2;
      endcase
    end
  end
endmodule

module ahb_split_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hsel,
  input logic [1:0]  htrans,
  input logic        hready,
  input logic        mem_ready,
  input logic        hreadyout,
  input logic [1:0]  hresp,
  input logic [15:0] hsplit
);
  p_idle_zero_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && hreadyout && (!hsel || !htrans[1])) |=> (hreadyout && hresp == 2'b00));

  p_low_ready_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hreadyout && !hready) |=> (hreadyout && hresp == 2'b00));

  p_two_cycle_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hreadyout && hresp != 2'b00) |=> (hreadyout && hresp == $past(hresp)));

  p_split_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hsplit));

  p_split_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hsplit != 16'd0) |=> ((hsplit & $past(hsplit)) == 16'd0));

  p_split_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hsplit != 16'd0) |-> $past(mem_ready));
endmodule

bind ahb_split_slave ahb_split_slave_chk i_chk (
  .clk(clk), .rst_n(rst_n), .hsel(hsel), .htrans(htrans), .hready(hready),
  .mem_ready(mem_ready), .hreadyout(hreadyout), .hresp(hresp), .hsplit(hsplit)
);

// File: tb/test_ahb_split_slave.sv
module test_ahb_split_slave;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic        hready_en = 1'b1;
  logic [3:0]  hmaster = '0;
  logic        mem_ready = 1'b0;
  logic        hreadyout;
  logic [1:0]  hresp;
  logic [15:0] hsplit;
  wire         hready = hreadyout & hready_en;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  ahb_split_slave i_ahb_split_slave (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hready(hready), .hmaster(hmaster), .mem_ready(mem_ready),
    .hreadyout(hreadyout), .hresp(hresp), .hsplit(hsplit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic sel, input logic [1:0] tr, input logic wr,
                       input logic [31:0] a, input logic [3:0] m);
    @(negedge clk);
    hsel = sel; htrans = tr; hwrite = wr; haddr = a; hmaster = m;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 hreadyout in reset", hreadyout, 1);
    chk("R1 hresp in reset", hresp, 0);
    chk("R1 hsplit in reset", hsplit, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hreadyout after reset", hreadyout, 1);
    chk("R1 hsplit after reset", hsplit, 0);
  endtask

  task automatic t_ready_access;
    mem_ready = 1'b1;
    issue(1, 2'b10, 0, 32'h100, 4'd2);
    chk("R5 read zero wait", {hreadyout, hresp}, 3'b100);
    issue(1, 2'b11, 1, 32'h104, 4'd2);
    chk("R5 write zero wait", {hreadyout, hresp}, 3'b100);
    mem_ready = 1'b0;
  endtask

  task automatic t_idle_busy;
    issue(1, 2'b00, 0, 32'h200, 4'd1);
    chk("R2 IDLE ignored", {hreadyout, hresp}, 3'b100);
    issue(1, 2'b01, 0, 32'h200, 4'd1);
    chk("R2 BUSY ignored", {hreadyout, hresp}, 3'b100);
    issue(0, 2'b10, 0, 32'h200, 4'd1);
    chk("R2 unselected ignored", {hreadyout, hresp}, 3'b100);
  endtask

  task automatic t_hready_low;
    hready_en = 1'b0;
    issue(1, 2'b10, 0, 32'h300, 4'd3);
    hready_en = 1'b1;
    chk("R3 not sampled under low hready", {hreadyout, hresp}, 3'b100);
    @(negedge clk);
    chk("R3 still idle", {hreadyout, hresp}, 3'b100);
  endtask

  task automatic t_ro_write;
    issue(1, 2'b10, 1, 32'h8010, 4'd4);
    chk("R4 error first cycle", {hreadyout, hresp}, 3'b001);
    @(negedge clk);
    chk("R4 error second cycle", {hreadyout, hresp}, 3'b101);
    @(negedge clk);
    chk("R4 back to okay", {hreadyout, hresp}, 3'b100);
    mem_ready = 1'b1;
    issue(1, 2'b10, 0, 32'h8fff, 4'd4);
    chk("R4 read of protected window", {hreadyout, hresp}, 3'b100);
    mem_ready = 1'b0;
  endtask

  task automatic t_wait_states;
    issue(1, 2'b10, 0, 32'h400, 4'd6);
    chk("R6 first wait", {hreadyout, hresp}, 3'b000);
    @(negedge clk);
    chk("R6 second wait", {hreadyout, hresp}, 3'b000);
    mem_ready = 1'b1;
    @(negedge clk);
    chk("R6 completes okay", {hreadyout, hresp}, 3'b100);
    mem_ready = 1'b0;
  endtask

  task automatic run_split(input logic [3:0] m, input bit detail);
    issue(1, 2'b10, 0, 32'h500, m);
    if (detail) chk("R7 wait before split", {hreadyout, hresp}, 3'b000);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (detail) chk("R7 wait up to limit", {hreadyout, hresp}, 3'b000);
    end
    @(negedge clk);
    if (detail) chk("R7 split first cycle", {hreadyout, hresp}, 3'b011);
    @(negedge clk);
    if (detail) chk("R7 split second cycle", {hreadyout, hresp}, 3'b111);
    @(negedge clk);
    if (detail) chk("R7 okay after split", {hreadyout, hresp}, 3'b100);
  endtask

  task automatic t_split;
    run_split(4'd9, 1'b1);
    run_split(4'd5, 1'b0);
    chk("R7 second split ends", {hreadyout, hresp}, 3'b100);
    repeat (3) @(negedge clk);
    chk("R10 no pulse while store busy", hsplit, 0);
    mem_ready = 1'b1;
    @(negedge clk);
    chk("R8 lowest master first", hsplit, 32'h0020);
    @(negedge clk);
    chk("R8 next master", hsplit, 32'h0200);
    @(negedge clk);
    chk("R8 pulses end", hsplit, 0);
    mem_ready = 1'b0;
  endtask

  task automatic t_retry;
    issue(1, 2'b10, 0, 32'h500, 4'd9);
    chk("R9 retry zero wait with store busy", {hreadyout, hresp}, 3'b100);
    issue(1, 2'b10, 0, 32'h504, 4'd9);
    chk("R9 record cleared, fresh access waits", {hreadyout, hresp}, 3'b000);
    mem_ready = 1'b1;
    @(negedge clk);
    chk("R9 fresh access completes", {hreadyout, hresp}, 3'b100);
    chk("R9 no repeat pulse", hsplit, 0);
    @(negedge clk);
    chk("R9 still no repeat pulse", hsplit, 0);
    mem_ready = 1'b0;
    issue(1, 2'b10, 0, 32'h500, 4'd5);
    chk("R9 second master retry okay", {hreadyout, hresp}, 3'b100);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_ready_access();
    t_idle_busy();
    t_hready_low();
    t_ro_write();
    t_wait_states();
    t_split();
    t_retry();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog, all requirements: actual hang expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule